// File: doc/BRIEF.md
# Per-Queue Packet Ready Tracker

This block follows whole packets as they pass through a set of queues whose storage lives elsewhere. It watches the end-of-packet marker on every word written to a queue and on every word read back out. From these it keeps a count of complete packets for each queue. The write side and the read side share one clock here.

For the queue currently selected on the read side, it drives an active-low ready flag. It also refuses reads from a queue that holds no complete packet. A separate ready bus reports a group of queues at once. In direct mode the group comes from a select input. In polled mode the bus visits the groups in turn and outputs the index of the group it is showing.

Two modes are fixed at a synchronous master reset (`mrs`): whether packet tracking is on, and whether the ready bus runs direct or polled. The end marker is bit 35 of the 36-bit data word on both the write and the read side. The storage wrapper feeds that bit to `wr_eop` and `rd_eop`.

Top module: `pkt_ready_tracker`

## Requirements
- R1: Packet mode (`pkt_mode_in`) and bus mode (`flag_mode_in`: 0 direct, 1 polled) are captured only on a clock edge with `mrs` high. Changes to these inputs at other times have no effect.
- R2: With packet mode off, `pr_n` is 1, every bit of `pr_bus_n` is 1, and `rd_grant` equals `rd_en`.
- R3: In packet mode, a write (`wr_en`=1) with `wr_eop`=1 adds one to the packet count of queue `wr_q` at that clock edge.
- R4: A granted read (`rd_grant`=1) with `rd_eop`=1 subtracts one from the count of queue `rd_q`. A read without a grant, or without the end marker, leaves the count unchanged.
- R5: `pr_n` is 0 exactly when packet mode is on and the queue selected by `rd_q` has a non-zero count. The counts of other queues do not affect it.
- R6: In packet mode, `rd_grant` = `rd_en` AND NOT `pr_n` AND NOT `ov_n`. A queue with no complete packet is never read, whatever `rd_en` does.
- R7: A write with the end marker and a granted read with the end marker to the same queue in one cycle leave that queue's count unchanged.
- R8: In direct mode, `pr_grp` equals `grp_sel`. Bit k of `pr_bus_n` is the active-low ready of queue `pr_grp`*GROUP+k.
- R9: In polled mode, `pr_grp` is 0 after master reset and moves to the next group on every clock, wrapping after the last. `pr_bus_n` decodes as in R8.
- R10: After the asynchronous reset, packet mode is off, the bus is direct, all counts are zero and the polling index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs | input | 1 | Synchronous master reset: latches modes, clears counts and poll index |
| pkt_mode_in | input | 1 | Packet-mode select, sampled during `mrs` |
| flag_mode_in | input | 1 | Bus mode select (0 direct, 1 polled), sampled during `mrs` |
| wr_en | input | 1 | A word is written this cycle |
| wr_q | input | QW | Queue receiving the written word |
| wr_eop | input | 1 | End marker (data bit 35) of the written word |
| rd_en | input | 1 | Read requested this cycle |
| rd_q | input | QW | Queue selected on the read side |
| rd_eop | input | 1 | End marker (data bit 35) of the word at the read head |
| ov_n | input | 1 | Active-low output-valid from the storage |
| grp_sel | input | GW | Group shown on the bus in direct mode |
| pr_n | output | 1 | Active-low packet ready of the read-selected queue |
| rd_grant | output | 1 | Read actually performed this cycle |
| pr_bus_n | output | GROUP | Active-low packet ready of the shown group |
| pr_grp | output | GW | Index of the group shown on `pr_bus_n` |

## Verification
The properties assume that the storage never lets a queue reach the count limit. They also assume that `rd_eop` is set only on words that truly carry the end marker, so a granted end-marker read always finds a non-zero count. The stimulus writes at most two packets into any queue before reading them back. It takes read markers from the packet layout it has just written. The polling and balance properties are disabled across `mrs` edges, because those edges clear the state.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef enum logic {
    BUS_DIRECT = 1'b0,
    BUS_POLLED = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic      pkt;
    bus_mode_e bus;
  } mode_t;
endpackage

// File: rtl/prt_mode_reg.sv
module prt_mode_reg
  import prt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mrs,
  input  logic  pkt_in,
  input  logic  flag_in,
  output mode_t mode_o
);
  mode_t mode_q, mode_d;

  always_comb begin
    mode_d     = mode_q;
    mode_d.pkt = pkt_in;
    mode_d.bus = bus_mode_e'(flag_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{pkt: 1'b0, bus: BUS_DIRECT};
    end else if (mrs) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/prt_pkt_counter.sv
module prt_pkt_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          nz
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr | (inc ^ dec);

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CW'(1);
    else          cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign nz  = |cnt_q;
endmodule

// File: rtl/prt_poll_seq.sv
module prt_poll_seq #(
  parameter int NGRP = 2,
  parameter int GW   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [GW-1:0] grp
);
  logic [GW-1:0] grp_q, grp_d;
  logic          grp_en;

  assign grp_en = clr | step;

  always_comb begin
    if (clr || grp_q == GW'(NGRP - 1)) grp_d = '0;
    else                               grp_d = grp_q + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grp_q <= '0;
    else if (grp_en) grp_q <= grp_d;
  end

  assign grp = grp_q;
endmodule

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker
  import prt_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int GROUP = 2,
  parameter int CW    = 4,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int NGRP = NQ / GROUP,
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs,
  input  logic             pkt_mode_in,
  input  logic             flag_mode_in,
  input  logic             wr_en,
  input  logic [QW-1:0]    wr_q,
  input  logic             wr_eop,
  input  logic             rd_en,
  input  logic [QW-1:0]    rd_q,
  input  logic             rd_eop,
  input  logic             ov_n,
  input  logic [GW-1:0]    grp_sel,
  output logic             pr_n,
  output logic             rd_grant,
  output logic [GROUP-1:0] pr_bus_n,
  output logic [GW-1:0]    pr_grp
);
  mode_t            mode;
  logic             pkt_on;
  logic             poll_on;
  logic [NQ-1:0]    cnt_nz;
  logic [NQ*CW-1:0] cnt_flat;
  logic [GW-1:0]    poll_grp;
  logic [GROUP-1:0] grp_ready;
  logic             sel_ready;

  prt_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mrs     (mrs),
    .pkt_in  (pkt_mode_in),
    .flag_in (flag_mode_in),
    .mode_o  (mode)
  );

  assign pkt_on  = mode.pkt;
  assign poll_on = mode.pkt & (mode.bus == BUS_POLLED);

  // Per-queue complete-packet counters
  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic inc, dec;
    assign inc = pkt_on & wr_en & wr_eop & (wr_q == QW'(q));
    assign dec = pkt_on & rd_grant & rd_eop & (rd_q == QW'(q));
    prt_pkt_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (mrs),
      .inc   (inc),
      .dec   (dec),
      .cnt   (cnt_flat[q*CW +: CW]),
      .nz    (cnt_nz[q])
    );
  end

  // Discrete ready and read gating for the read-selected queue
  assign sel_ready = pkt_on & cnt_nz[rd_q];
  assign pr_n      = ~sel_ready;
  assign rd_grant  = rd_en & (~pkt_on | (sel_ready & ~ov_n));

  // Ready bus: direct select or polled sequence
  prt_poll_seq #(.NGRP(NGRP), .GW(GW)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mrs),
    .step  (poll_on),
    .grp   (poll_grp)
  );

  assign pr_grp = poll_on ? poll_grp : grp_sel;

  always_comb begin
    grp_ready = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (pr_grp == GW'(g)) grp_ready = cnt_nz[g*GROUP +: GROUP];
    end
  end

  assign pr_bus_n = ~(grp_ready & {GROUP{pkt_on}});
endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
  parameter int NQ    = 4,
  parameter int GROUP = 2,
  parameter int CW    = 4,
  parameter int QW    = 2,
  parameter int GW    = 1,
  parameter int NGRP  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mrs,
  input logic             pkt_on,
  input logic             poll_on,
  input logic             wr_en,
  input logic [QW-1:0]    wr_q,
  input logic             wr_eop,
  input logic             rd_en,
  input logic [QW-1:0]    rd_q,
  input logic             rd_eop,
  input logic             ov_n,
  input logic             rd_grant,
  input logic             pr_n,
  input logic [GROUP-1:0] pr_bus_n,
  input logic [GW-1:0]    pr_grp,
  input logic [NQ*CW-1:0] cnt_flat
);
  function automatic logic [CW-1:0] cnt_of(logic [NQ*CW-1:0] f, logic [QW-1:0] i);
    logic [CW-1:0] r;
    r = '0;
    for (int k = 0; k < NQ; k++) if (i == QW'(k)) r = f[k*CW +: CW];
    return r;
  endfunction

  function automatic logic [GW-1:0] grp_after(logic [GW-1:0] g);
    return (g == GW'(NGRP - 1)) ? '0 : g + GW'(1);
  endfunction

  // R6: a grant only ever comes with ready and valid both active
  a_r6_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_on && rd_grant) |-> (rd_en && !pr_n && !ov_n));

  // R2: nothing reported and nothing gated with packet mode off
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_on |-> (pr_n && (&pr_bus_n) && (rd_grant == rd_en)));

  // R7: same-queue end write and end read cancel
  a_r7_balance: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_on && !mrs && wr_en && wr_eop && rd_grant && rd_eop && wr_q == rd_q)
    |=> cnt_of(cnt_flat, $past(rd_q)) == $past(cnt_of(cnt_flat, rd_q)));

  // R3: an end-marked write alone raises its queue's count by one
  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_on && !mrs && wr_en && wr_eop && !(rd_grant && rd_eop && rd_q == wr_q))
    |=> cnt_of(cnt_flat, $past(wr_q)) == $past(cnt_of(cnt_flat, wr_q)) + CW'(1));

  // R9: polling index advances each clock
  a_r9_poll_step: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_on && !mrs) |=> pr_grp == grp_after($past(pr_grp)));
endmodule

bind pkt_ready_tracker prt_checker #(
  .NQ(NQ), .GROUP(GROUP), .CW(CW), .QW(QW), .GW(GW), .NGRP(NGRP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mrs      (mrs),
  .pkt_on   (pkt_on),
  .poll_on  (poll_on),
  .wr_en    (wr_en),
  .wr_q     (wr_q),
  .wr_eop   (wr_eop),
  .rd_en    (rd_en),
  .rd_q     (rd_q),
  .rd_eop   (rd_eop),
  .ov_n     (ov_n),
  .rd_grant (rd_grant),
  .pr_n     (pr_n),
  .pr_bus_n (pr_bus_n),
  .pr_grp   (pr_grp),
  .cnt_flat (cnt_flat)
);

// File: tb/pkt_ready_tracker_bench.sv
module pkt_ready_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n, mrs, pkt_mode_in, flag_mode_in;
  logic       wr_en, wr_eop, rd_en, rd_eop, ov_n;
  logic [1:0] wr_q, rd_q;
  logic [0:0] grp_sel;
  logic       pr_n, rd_grant;
  logic [1:0] pr_bus_n;
  logic [0:0] pr_grp;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pkt_ready_tracker u_pkt_ready_tracker (
    .clk(clk), .rst_n(rst_n), .mrs(mrs), .pkt_mode_in(pkt_mode_in),
    .flag_mode_in(flag_mode_in), .wr_en(wr_en), .wr_q(wr_q), .wr_eop(wr_eop),
    .rd_en(rd_en), .rd_q(rd_q), .rd_eop(rd_eop), .ov_n(ov_n),
    .grp_sel(grp_sel), .pr_n(pr_n), .rd_grant(rd_grant),
    .pr_bus_n(pr_bus_n), .pr_grp(pr_grp)
  );

  // fields: wen, wq[1:0], weop, ren, rq[1:0], reop, ovn, exp_pr_n, exp_grant
  localparam int NV = 15;
  localparam logic [10:0] VEC [NV] = '{
    11'b0_00_0_1_00_0_0_1_0,  // R6 empty queue, read refused
    11'b1_00_1_0_00_0_0_1_0,  // R3 end write to q0
    11'b0_00_0_0_00_0_0_0_0,  // R5 q0 ready
    11'b0_00_0_0_01_0_0_1_0,  // R5 q1 not ready
    11'b1_01_1_1_00_1_0_0_1,  // R4 read end from q0, R3 write q1
    11'b0_00_0_1_00_0_0_1_0,  // R4 q0 empty again
    11'b0_00_0_1_01_0_1_0_0,  // R6 ov_n high blocks read
    11'b1_01_1_1_01_1_0_0_1,  // R7 write+read end on q1
    11'b0_00_0_1_01_1_0_0_1,  // R7 q1 still one packet
    11'b1_10_1_1_01_0_0_1_0,  // R4 q1 empty, R3 write q2
    11'b1_10_1_1_10_0_0_0_1,  // R4 non-end read, second q2 packet
    11'b0_00_0_1_10_1_0_0_1,  // R4 end read, q2 at 1
    11'b0_00_0_0_10_0_0_0_0,  // R4 q2 still ready
    11'b0_00_0_1_10_1_0_0_1,  // R4 last packet read
    11'b0_00_0_0_10_0_0_1_0   // R4 q2 empty
  };

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_eop = 0; wr_q = 0;
    rd_en = 0; rd_eop = 0; rd_q = 0; ov_n = 0;
  endtask

  task automatic master_reset(logic p, logic f);
    @(negedge clk);
    mrs = 1; pkt_mode_in = p; flag_mode_in = f;
    @(negedge clk);
    mrs = 0;
  endtask

  initial begin
    rst_n = 0; mrs = 0; pkt_mode_in = 0; flag_mode_in = 0; grp_sel = 0;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10 pr_n", pr_n, 1);
    chk("R10 pr_bus_n", pr_bus_n, 3);
    chk("R10 pr_grp", pr_grp, 0);
    rd_en = 1; ov_n = 1;
    #1;
    chk("R2 grant passthrough", rd_grant, 1);
    idle();

    master_reset(1'b1, 1'b0);
    for (int i = 0; i < NV; i++) begin
      {wr_en, wr_q, wr_eop, rd_en, rd_q, rd_eop, ov_n} = VEC[i][10:2];
      #1;
      chk($sformatf("R5/R6 vec%0d pr_n", i), pr_n, VEC[i][1]);
      chk($sformatf("R6 vec%0d rd_grant", i), rd_grant, VEC[i][0]);
      @(negedge clk);
    end
    idle();

    // R8 direct bus
    wr_en = 1; wr_q = 3; wr_eop = 1;
    @(negedge clk);
    idle(); grp_sel = 1;
    #1;
    chk("R8 bus grp1", pr_bus_n, 1);
    chk("R8 grp index", pr_grp, 1);
    grp_sel = 0;
    #1;
    chk("R8 bus grp0", pr_bus_n, 3);

    // R1 mode inputs ignored outside mrs
    pkt_mode_in = 0; flag_mode_in = 1; rd_q = 3;
    @(negedge clk);
    chk("R1 still packet mode", pr_n, 0);
    chk("R1 still direct a", pr_grp, 0);
    @(negedge clk);
    chk("R1 still direct b", pr_grp, 0);
    idle();

    // R9 polled bus
    master_reset(1'b1, 1'b1);
    chk("R9 index after mrs", pr_grp, 0);
    wr_en = 1; wr_q = 1; wr_eop = 1;
    @(negedge clk);
    idle();
    chk("R9 step to 1", pr_grp, 1);
    chk("R9 bus grp1", pr_bus_n, 3);
    @(negedge clk);
    chk("R9 wrap to 0", pr_grp, 0);
    chk("R9 bus grp0", pr_bus_n, 1);
    @(negedge clk);
    chk("R9 step again", pr_grp, 1);

    // R2 packet mode off
    master_reset(1'b0, 1'b0);
    wr_en = 1; wr_q = 0; wr_eop = 1;
    @(negedge clk);
    idle(); rd_en = 1; ov_n = 1;
    #1;
    chk("R2 pr_n high", pr_n, 1);
    chk("R2 bus idle", pr_bus_n, 3);
    chk("R2 no gating", rd_grant, 1);
    idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule